// File: doc/BRIEF.md
# Flash Command Front End

This block is the command decoder that sits in front of a byte-wide flash array with a protected boot region. It receives a sampled memory bus carrying an active-low chip select, output strobe, write strobe and sleep/reset line, a 17-bit address and an 8-bit data byte. On every completed write it latches address and data. It then interprets single-byte and two-byte command sequences. These sequences choose what a read returns: array contents, identification bytes or a status byte. They can also start, pause and continue a program or erase job on a separate write engine.

The write engine reports completion on a one-cycle done pulse with a failure flag. The block keeps track of which job is running and whether an erase is paused, and reflects both in the status byte. The programming-supply check arrives as a single digital flag that is sampled when a job would start. The read path selects the byte for the bus and raises a drive-enable only when the part is selected, reading and awake.

Top module: `flashcmd_front`

## Requirements
- R1: After reset, and in the first cycle after the sleep line returns high, reads return array data (`array_rdata`); writing FFH also selects array reads when no job is running.
- R2: After writing 90H, a read at address 0 returns 89H, at address 1 returns the device code (94H when `TOP_BOOT`=1, 95H otherwise), and at any other address returns 00H.
- R3: After writing 70H every read returns the status byte: bit 7 ready, bit 6 erase paused, bit 5 erase error, bit 4 program error, bit 3 supply error, bits 2..0 zero. Writing 50H clears bits 5, 4 and 3 and does not change the read selection.
- R4: 40H followed by a data byte issues one program request (`req_op`=0) carrying the second write's address and data; 20H followed by D0H issues one erase request (`req_op`=1) carrying the second write's address. Each request is a one-cycle `req_valid` pulse.
- R5: Launching a job switches reads to the status byte with ready low, without a 70H write.
- R6: While a job runs and is not paused, FFH, 90H, 50H, 20H and 40H are ignored; reads stay on the status byte.
- R7: B0H during a running erase issues a pause request (`req_op`=2) and sets status bits 7 and 6; while paused, FFH gives array reads; D0H then issues a resume request (`req_op`=3) and clears bits 7 and 6.
- R8: An engine done pulse sets ready; with the failure flag it also sets the erase error bit for an erase job or the program error bit for a program job.
- R9: If the byte following 20H is not D0H, no request is issued, status bits 5 and 4 are set and reads switch to the status byte.
- R10: If `vpp_ok` is low at the second write of a program or erase sequence, no request is issued and the supply error bit plus that job's error bit are set.
- R11: A write strobe edge while chip select is high has no effect.
- R12: While the sleep line is low, `eng_abort` is high, no request is issued, the running job is dropped and the status error bits are cleared.
- R13: `rd_oe` is high only when chip select and output strobe are low and the sleep line is high; `rd_data` is 00H whenever `rd_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock of the sampled bus domain |
| rst | input | 1 | Synchronous active-high reset |
| bus_ce_n | input | 1 | Chip select, active low |
| bus_oe_n | input | 1 | Output strobe, active low |
| bus_we_n | input | 1 | Write strobe, active low; capture on its rising edge |
| bus_pd_n | input | 1 | Sleep/reset line, active low |
| bus_addr | input | 17 | Byte address |
| bus_wdata | input | 8 | Write data or command byte |
| vpp_ok | input | 1 | Programming supply in range |
| array_rdata | input | 8 | Array byte at `bus_addr` |
| eng_done | input | 1 | Engine finished the running job (one-cycle pulse) |
| eng_fail | input | 1 | Qualifies `eng_done` as a failed job |
| rd_data | output | 8 | Byte for the data bus |
| rd_oe | output | 1 | Data bus drive enable |
| req_valid | output | 1 | Engine request pulse |
| req_op | output | 2 | 0 program, 1 erase, 2 pause, 3 resume |
| req_addr | output | 17 | Request address |
| req_data | output | 8 | Request data byte |
| eng_abort | output | 1 | Abort the running job |

## Verification
A corrupted read selection shows on the very next read as the wrong source byte, for example array data where status was expected after a launch, so every mode step is followed by a read. A lost or stale run or pause flag shows in bits 7 and 6 of the status byte and in whether FFH restores array reads, and a lost sequence stage shows as a missing or extra request pulse two cycles after the write strobe rises, which a request scoreboard catches. Sticky error bits that fail to clear or set appear in the status byte on the read that follows the 50H write, the rejected sequence, or the done pulse.

// File: rtl/flashcmd_pkg.sv
package flashcmd_pkg;

    localparam int ADDR_W = 17;
    localparam int DATA_W = 8;

    // command bytes
    localparam logic [DATA_W-1:0] CMD_READ  = 8'hFF;
    localparam logic [DATA_W-1:0] CMD_IDENT = 8'h90;
    localparam logic [DATA_W-1:0] CMD_STAT  = 8'h70;
    localparam logic [DATA_W-1:0] CMD_CLR   = 8'h50;
    localparam logic [DATA_W-1:0] CMD_ERASE = 8'h20;
    localparam logic [DATA_W-1:0] CMD_PROG  = 8'h40;
    localparam logic [DATA_W-1:0] CMD_CONF  = 8'hD0;
    localparam logic [DATA_W-1:0] CMD_SUSP  = 8'hB0;

    // identification bytes
    localparam logic [DATA_W-1:0] ID_MFR     = 8'h89;
    localparam logic [DATA_W-1:0] ID_DEV_TOP = 8'h94;
    localparam logic [DATA_W-1:0] ID_DEV_BOT = 8'h95;

    typedef enum logic [1:0] {
        RM_ARRAY  = 2'd0,
        RM_IDENT  = 2'd1,
        RM_STATUS = 2'd2
    } rmode_e;

    typedef enum logic [1:0] {
        OP_PROG    = 2'd0,
        OP_ERASE   = 2'd1,
        OP_SUSPEND = 2'd2,
        OP_RESUME  = 2'd3
    } eop_e;

    typedef enum logic [1:0] {
        RUN_IDLE  = 2'd0,
        RUN_PROG  = 2'd1,
        RUN_ERASE = 2'd2
    } run_e;

    typedef enum logic [1:0] {
        PD_NONE  = 2'd0,
        PD_ERASE = 2'd1,
        PD_PROG  = 2'd2
    } pend_e;

    typedef struct packed {
        logic ready;
        logic esusp;
        logic eerr;
        logic perr;
        logic verr;
    } stat_t;

    typedef struct packed {
        logic              valid;
        eop_e              op;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } ereq_t;

    function automatic logic [DATA_W-1:0] stat_byte(input stat_t s);
        return {s.ready, s.esusp, s.eerr, s.perr, s.verr, 3'b000};
    endfunction

endpackage

// File: rtl/flashcmd_wcap.sv
module flashcmd_wcap
    import flashcmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              stb,
    output logic [ADDR_W-1:0] cap_addr,
    output logic [DATA_W-1:0] cap_data
);

    logic we_q;
    logic edge_ok;

    // rising write strobe qualified by chip select
    assign edge_ok = !we_q && we_n && !ce_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            we_q     <= 1'b1;
            stb      <= 1'b0;
            cap_addr <= '0;
            cap_data <= '0;
        end else begin
            we_q <= we_n;
            stb  <= edge_ok;
            if (edge_ok) begin
                cap_addr <= addr;
                cap_data <= wdata;
            end
        end
    end

endmodule

// File: rtl/flashcmd_seq.sv
module flashcmd_seq
    import flashcmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              stb,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              vpp_ok,
    input  logic              eng_done,
    input  logic              eng_fail,
    output rmode_e            mode,
    output stat_t             stat,
    output ereq_t             req,
    output run_e              run,
    output logic              susp
);

    pend_e pend;
    logic  eerr, perr, verr;
    logic  busy_c;

    assign busy_c = (run != RUN_IDLE) && !susp;

    assign stat.ready = (run == RUN_IDLE) || susp;
    assign stat.esusp = susp;
    assign stat.eerr  = eerr;
    assign stat.perr  = perr;
    assign stat.verr  = verr;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode <= RM_ARRAY;
            pend <= PD_NONE;
            run  <= RUN_IDLE;
            susp <= 1'b0;
            eerr <= 1'b0;
            perr <= 1'b0;
            verr <= 1'b0;
            req  <= '0;
        end else begin
            req.valid <= 1'b0;

            // engine completion
            if (eng_done && run != RUN_IDLE) begin
                run  <= RUN_IDLE;
                susp <= 1'b0;
                if (eng_fail) begin
                    if (run == RUN_ERASE) eerr <= 1'b1;
                    else                  perr <= 1'b1;
                end
            end

            if (stb) begin
                if (pend == PD_ERASE) begin
                    pend <= PD_NONE;
                    mode <= RM_STATUS;
                    if (wdata == CMD_CONF) begin
                        if (vpp_ok) begin
                            run      <= RUN_ERASE;
                            req      <= '{valid: 1'b1, op: OP_ERASE,
                                          addr: waddr, data: wdata};
                        end else begin
                            verr <= 1'b1;
                            eerr <= 1'b1;
                        end
                    end else begin
                        eerr <= 1'b1;
                        perr <= 1'b1;
                    end
                end else if (pend == PD_PROG) begin
                    pend <= PD_NONE;
                    mode <= RM_STATUS;
                    if (vpp_ok) begin
                        run <= RUN_PROG;
                        req <= '{valid: 1'b1, op: OP_PROG,
                                 addr: waddr, data: wdata};
                    end else begin
                        verr <= 1'b1;
                        perr <= 1'b1;
                    end
                end else if (busy_c) begin
                    case (wdata)
                        CMD_STAT: mode <= RM_STATUS;
                        CMD_SUSP: begin
                            if (run == RUN_ERASE) begin
                                susp <= 1'b1;
                                mode <= RM_STATUS;
                                req  <= '{valid: 1'b1, op: OP_SUSPEND,
                                          addr: waddr, data: wdata};
                            end
                        end
                        default: ;
                    endcase
                end else if (susp) begin
                    case (wdata)
                        CMD_CONF: begin
                            susp <= 1'b0;
                            mode <= RM_STATUS;
                            req  <= '{valid: 1'b1, op: OP_RESUME,
                                      addr: waddr, data: wdata};
                        end
                        CMD_READ:  mode <= RM_ARRAY;
                        CMD_IDENT: mode <= RM_IDENT;
                        CMD_STAT:  mode <= RM_STATUS;
                        CMD_CLR: begin
                            eerr <= 1'b0;
                            perr <= 1'b0;
                            verr <= 1'b0;
                        end
                        default: ;
                    endcase
                end else begin
                    case (wdata)
                        CMD_READ:  mode <= RM_ARRAY;
                        CMD_IDENT: mode <= RM_IDENT;
                        CMD_STAT:  mode <= RM_STATUS;
                        CMD_CLR: begin
                            eerr <= 1'b0;
                            perr <= 1'b0;
                            verr <= 1'b0;
                        end
                        CMD_ERASE: pend <= PD_ERASE;
                        CMD_PROG:  pend <= PD_PROG;
                        default: ;
                    endcase
                end
            end
        end
    end

endmodule

// File: rtl/flashcmd_rdmux.sv
module flashcmd_rdmux
    import flashcmd_pkg::*;
#(
    parameter bit TOP_BOOT = 1'b1
) (
    input  rmode_e            mode,
    input  stat_t             stat,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] array_rdata,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              pd_n,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_oe
);

    logic [DATA_W-1:0] dev_code;
    logic [DATA_W-1:0] id_byte;
    logic [DATA_W-1:0] sel;

    generate
        if (TOP_BOOT) begin : g_top
            assign dev_code = ID_DEV_TOP;
        end else begin : g_bot
            assign dev_code = ID_DEV_BOT;
        end
    endgenerate

    always_comb begin
        if (addr == ADDR_W'(0))      id_byte = ID_MFR;
        else if (addr == ADDR_W'(1)) id_byte = dev_code;
        else                         id_byte = '0;
    end

    always_comb begin
        case (mode)
            RM_IDENT:  sel = id_byte;
            RM_STATUS: sel = stat_byte(stat);
            default:   sel = array_rdata;
        endcase
    end

    assign rd_oe   = !ce_n && !oe_n && pd_n;
    assign rd_data = rd_oe ? sel : '0;

endmodule

// File: rtl/flashcmd_front.sv
module flashcmd_front
    import flashcmd_pkg::*;
#(
    parameter bit TOP_BOOT = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_ce_n,
    input  logic              bus_oe_n,
    input  logic              bus_we_n,
    input  logic              bus_pd_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              vpp_ok,
    input  logic [DATA_W-1:0] array_rdata,
    input  logic              eng_done,
    input  logic              eng_fail,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_oe,
    output logic              req_valid,
    output logic [1:0]        req_op,
    output logic [ADDR_W-1:0] req_addr,
    output logic [DATA_W-1:0] req_data,
    output logic              eng_abort
);

    logic              core_rst;
    logic              wr_stb;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data;
    rmode_e            mode;
    stat_t             stat;
    ereq_t             req;
    run_e              run;
    logic              susp;

    assign core_rst  = rst || !bus_pd_n;
    assign eng_abort = !bus_pd_n;

    flashcmd_wcap u_wcap (
        .clk      (clk),
        .rst      (core_rst),
        .ce_n     (bus_ce_n),
        .we_n     (bus_we_n),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .stb      (wr_stb),
        .cap_addr (wr_addr),
        .cap_data (wr_data)
    );

    flashcmd_seq u_seq (
        .clk      (clk),
        .rst      (core_rst),
        .stb      (wr_stb),
        .waddr    (wr_addr),
        .wdata    (wr_data),
        .vpp_ok   (vpp_ok),
        .eng_done (eng_done),
        .eng_fail (eng_fail),
        .mode     (mode),
        .stat     (stat),
        .req      (req),
        .run      (run),
        .susp     (susp)
    );

    flashcmd_rdmux #(.TOP_BOOT(TOP_BOOT)) u_rd (
        .mode        (mode),
        .stat        (stat),
        .addr        (bus_addr),
        .array_rdata (array_rdata),
        .ce_n        (bus_ce_n),
        .oe_n        (bus_oe_n),
        .pd_n        (bus_pd_n),
        .rd_data     (rd_data),
        .rd_oe       (rd_oe)
    );

    assign req_valid = req.valid;
    assign req_op    = req.op;
    assign req_addr  = req.addr;
    assign req_data  = req.data;

endmodule

// File: rtl/flashcmd_chk.sv
module flashcmd_chk
    import flashcmd_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              bus_pd_n,
    input logic              wr_stb,
    input logic [DATA_W-1:0] wr_data,
    input logic              req_valid,
    input logic [1:0]        req_op,
    input rmode_e            mode,
    input run_e              run,
    input logic              susp
);

    // R4
    req_after_write_chk: assert property (@(posedge clk) disable iff (rst || !bus_pd_n)
        req_valid |-> $past(wr_stb));

    // R6
    busy_read_ignored_chk: assert property (@(posedge clk) disable iff (rst || !bus_pd_n)
        (wr_stb && wr_data == CMD_READ && run != RUN_IDLE && !susp) |=> (mode != RM_ARRAY));

    // R7
    pause_only_erase_chk: assert property (@(posedge clk) disable iff (rst || !bus_pd_n)
        (req_valid && req_op == 2'd2) |-> (susp && run == RUN_ERASE));

    // R1
    wake_array_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_pd_n) |-> (mode == RM_ARRAY));

    // R12
    sleep_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !bus_pd_n |=> !req_valid);

endmodule

bind flashcmd_front flashcmd_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_pd_n  (bus_pd_n),
    .wr_stb    (wr_stb),
    .wr_data   (wr_data),
    .req_valid (req_valid),
    .req_op    (req_op),
    .mode      (mode),
    .run       (run),
    .susp      (susp)
);

// File: tb/sim_flashcmd_front.sv
module sim_flashcmd_front;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_ce_n = 1'b1;
    logic        bus_oe_n = 1'b1;
    logic        bus_we_n = 1'b1;
    logic        bus_pd_n = 1'b1;
    logic [16:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic        vpp_ok = 1'b1;
    logic [7:0]  array_rdata;
    logic        eng_done = 1'b0;
    logic        eng_fail = 1'b0;
    logic [7:0]  rd_data;
    logic        rd_oe;
    logic        req_valid;
    logic [1:0]  req_op;
    logic [16:0] req_addr;
    logic [7:0]  req_data;
    logic        eng_abort;

    int n_chk = 0;
    int n_bad = 0;

    typedef struct {
        string       tag;
        logic [1:0]  op;
        logic [16:0] addr;
        logic [7:0]  data;
    } exp_t;

    exp_t sb[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    assign array_rdata = bus_addr[7:0] ^ 8'h3C;

    flashcmd_front #(.TOP_BOOT(1'b1)) u0 (
        .clk(clk), .rst(rst), .bus_ce_n(bus_ce_n), .bus_oe_n(bus_oe_n),
        .bus_we_n(bus_we_n), .bus_pd_n(bus_pd_n), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .vpp_ok(vpp_ok), .array_rdata(array_rdata),
        .eng_done(eng_done), .eng_fail(eng_fail), .rd_data(rd_data),
        .rd_oe(rd_oe), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_data(req_data), .eng_abort(eng_abort)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // monitor: compare each request pulse with the scoreboard head
    always @(negedge clk) begin
        if (!rst && req_valid) begin
            if (sb.size() == 0) begin
                chk("R4 unexpected request", {req_op, req_addr, req_data}, 32'hFFFF_FFFF);
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk(e.tag, {req_op, req_addr, req_data}, {e.op, e.addr, e.data});
            end
        end
    end

    task automatic expect_req(input string tag, input logic [1:0] op,
                              input logic [16:0] a, input logic [7:0] d);
        exp_t e;
        e.tag = tag; e.op = op; e.addr = a; e.data = d;
        sb.push_back(e);
    endtask

    task automatic bus_write(input logic [16:0] a, input logic [7:0] d, input bit sel = 1'b1);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_ce_n = !sel; bus_we_n = 1'b0;
        repeat (2) @(negedge clk);
        bus_we_n = 1'b1;
        @(negedge clk);
        bus_ce_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic bus_read(input logic [16:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk);
        bus_addr = a; bus_ce_n = 1'b0; bus_oe_n = 1'b0;
        #1;
        chk({tag, " oe"}, rd_oe, 1);
        chk(tag, rd_data, exp);
        @(negedge clk);
        bus_ce_n = 1'b1; bus_oe_n = 1'b1;
    endtask

    task automatic done_pulse(input bit fail);
        @(negedge clk);
        eng_done = 1'b1; eng_fail = fail;
        @(negedge clk);
        eng_done = 1'b0; eng_fail = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R13 reset state: not driving
        chk("R13 idle oe", rd_oe, 0);
        chk("R13 idle data", rd_data, 0);
        bus_read(17'h00012, 8'h2E, "R1 array after reset");

        // R11: deselected write ignored
        bus_write(17'h0, 8'h90, 1'b0);
        bus_read(17'h00012, 8'h2E, "R11 deselected write ignored");

        // R2 identifier
        bus_write(17'h0, 8'h90);
        bus_read(17'h00000, 8'h89, "R2 mfr code");
        bus_read(17'h00001, 8'h94, "R2 dev code");
        bus_read(17'h00002, 8'h00, "R2 other offset");

        // R3 status
        bus_write(17'h0, 8'h70);
        bus_read(17'h00005, 8'h80, "R3 status ready");

        // R4/R5 program
        bus_write(17'h01234, 8'h40);
        expect_req("R4 program request", 2'd0, 17'h01234, 8'hA7);
        bus_write(17'h01234, 8'hA7);
        bus_read(17'h00777, 8'h00, "R5 auto status busy");
        bus_write(17'h0, 8'hFF);
        bus_read(17'h00012, 8'h00, "R6 FF ignored while busy");
        bus_write(17'h0, 8'h90);
        bus_read(17'h00000, 8'h00, "R6 90 ignored while busy");
        done_pulse(1'b0);
        bus_read(17'h00012, 8'h80, "R8 done sets ready");
        bus_write(17'h0, 8'hFF);
        bus_read(17'h00012, 8'h2E, "R1 FF back to array");

        // R7 erase with pause/resume
        bus_write(17'h1E000, 8'h20);
        expect_req("R4 erase request", 2'd1, 17'h1E010, 8'hD0);
        bus_write(17'h1E010, 8'hD0);
        bus_read(17'h00012, 8'h00, "R5 erase busy");
        expect_req("R7 pause request", 2'd2, 17'h00000, 8'hB0);
        bus_write(17'h0, 8'hB0);
        bus_read(17'h00012, 8'hC0, "R7 paused status");
        bus_write(17'h0, 8'hFF);
        bus_read(17'h00012, 8'h2E, "R7 array while paused");
        expect_req("R7 resume request", 2'd3, 17'h00000, 8'hD0);
        bus_write(17'h0, 8'hD0);
        bus_read(17'h00012, 8'h00, "R7 resumed busy");
        done_pulse(1'b1);
        bus_read(17'h00012, 8'hA0, "R8 erase failure bit");
        bus_write(17'h0, 8'h50);
        bus_read(17'h00012, 8'h80, "R3 clear errors");

        // R9 rejected erase
        bus_write(17'h03000, 8'h20);
        bus_write(17'h03000, 8'h33);
        bus_read(17'h00012, 8'hB0, "R9 bad confirm");
        bus_write(17'h0, 8'h50);

        // R10 supply low
        vpp_ok = 1'b0;
        bus_write(17'h00100, 8'h40);
        bus_write(17'h00100, 8'h55);
        bus_read(17'h00012, 8'h98, "R10 supply error");
        vpp_ok = 1'b1;
        bus_write(17'h0, 8'h50);
        bus_read(17'h00012, 8'h80, "R10 cleared");

        // R12 sleep aborts a running program
        bus_write(17'h00200, 8'h40);
        expect_req("R12 program before sleep", 2'd0, 17'h00200, 8'h11);
        bus_write(17'h00200, 8'h11);
        @(negedge clk);
        bus_pd_n = 1'b0; bus_ce_n = 1'b0; bus_oe_n = 1'b0;
        #1;
        chk("R12 abort high", eng_abort, 1);
        chk("R13 no drive asleep", rd_oe, 0);
        chk("R13 data zero asleep", rd_data, 0);
        repeat (2) @(negedge clk);
        bus_pd_n = 1'b1; bus_ce_n = 1'b1; bus_oe_n = 1'b1;
        #1;
        chk("R12 abort low", eng_abort, 0);
        bus_read(17'h00012, 8'h2E, "R1 array after wake");
        bus_write(17'h0, 8'h70);
        bus_read(17'h00012, 8'h80, "R12 job dropped");

        repeat (3) @(negedge clk);
        chk("R4 all requests seen", sb.size(), 0);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule